// File: doc/BRIEF.md
# Processor-Side Interrupt Interface

This block sits between an interrupt distributor and one processor. It watches the vector of pending interrupts (each with an 8-bit priority) and picks the most urgent one. It checks that candidate against a software-set priority threshold and against the priority of whatever the processor is already handling. When the candidate passes both tests, it drives a single interrupt request line. Software works through a 32-bit register port. Reading the claim register hands back the winning interrupt number and records it as in service. Writing that number to the completion register retires it.

In-service interrupts live on a small last-in-first-out store of priorities, so a handler can be interrupted by a more urgent one and the earlier level comes back when the nested handler completes. A programmable split point divides each priority into an upper "group" part and a lower "sub" part. Only the group part decides whether a new interrupt may cut in on a running one. Claim and completion are also reported to the distributor as one-cycle pulses carrying the interrupt number.

Request signalling is a three-state machine. `SIG_OFF` means the interface is disabled. `SIG_QUIET` means it is enabled with nothing to signal. `SIG_RAISED` means the request line is high. The transitions are:
- T_ENABLE: `SIG_OFF` to `SIG_QUIET`, when enabled with no candidate.
- T_ENABLE_RAISE: `SIG_OFF` to `SIG_RAISED`, when enabled with a qualifying candidate.
- T_RAISE: `SIG_QUIET` to `SIG_RAISED`, when a candidate qualifies.
- T_DROP: `SIG_RAISED` to `SIG_QUIET`, when no candidate qualifies any more.
- T_DISABLE: any state to `SIG_OFF`, when the enable bit is cleared.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the request line is low, control, threshold and split point read 0, running priority reads 0xFF, and both the pending-query and the claim register read 1023.
- R2: Reads return on `bus_rdata` with `bus_rvalid` one cycle after `bus_rd`. The offsets are: control 0x000 (bit 0 is the enable), threshold 0x004 (bits 7:0), split point 0x008 (bits 2:0), claim 0x00C, completion 0x010 (reads 0), running priority 0x014, pending query 0x018, spare split-point storage 0x01C (bits 2:0), and identity 0x0FC, which returns `IFACE_ID`. All other offsets read 0. A write wins over a read in the same cycle.
- R3: The candidate is the pending interrupt with the numerically smallest priority, with ties going to the lowest number. The pending query reports it when it qualifies.
- R4: A candidate qualifies only if its priority is strictly below the threshold. A priority equal to the threshold is held back.
- R5: With the enable bit at 0 the request line stays low. With it at 1, the line rises on the clock edge after a candidate qualifies.
- R6: A read of the claim register with a qualifying candidate returns its number. The following cycle, `claim_valid` is high with that number on `claim_id`, and running priority equals the claimed priority.
- R7: A read of the claim register with nothing qualifying returns 1023. It gives no claim pulse and leaves running priority unchanged.
- R8: While an interrupt is in service, a candidate qualifies only if its group part (its priority with the low split+1 bits cleared) is strictly less than the group part of the running priority.
- R9: Writing the number of the most recent in-service interrupt to the completion register retires it. `done_valid`/`done_id` pulse the next cycle and the previous running priority returns. A different number, or a write with nothing in service, is ignored.
- R10: At most `STACK_DEPTH` interrupts are in service at once. When the store is full nothing qualifies until a completion frees a place.
- R11: The request line falls on the clock edge after a claim that leaves no qualifying candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend | input | NUM_IRQ | Pending and enabled interrupts from the distributor |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority of each interrupt, interrupt i at bits i*PRIO_W upward |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_out | output | 1 | Interrupt request to the processor |
| claim_valid | output | 1 | One-cycle pulse: an interrupt was claimed |
| claim_id | output | 10 | Number of the claimed interrupt |
| done_valid | output | 1 | One-cycle pulse: an interrupt was retired |
| done_id | output | 10 | Number of the retired interrupt |

## Verification
The bench builds the block with `NUM_IRQ` = 16, `PRIO_W` = 8 and `STACK_DEPTH` = 4. Four in-service levels mean the bench reaches the full store, and the rejection of a fifth, more urgent interrupt, after only four claims. The full 8-bit priority lets the bench move the split point from its finest to its coarsest setting. The same pair of priorities then flips between preempting and not preempting.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

    localparam int unsigned ID_W = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    localparam logic [11:0] OFS_CTRL    = 12'h000;
    localparam logic [11:0] OFS_PMASK   = 12'h004;
    localparam logic [11:0] OFS_SPLIT   = 12'h008;
    localparam logic [11:0] OFS_CLAIM   = 12'h00C;
    localparam logic [11:0] OFS_DONE    = 12'h010;
    localparam logic [11:0] OFS_RUN     = 12'h014;
    localparam logic [11:0] OFS_HIPEND  = 12'h018;
    localparam logic [11:0] OFS_SPLIT2  = 12'h01C;
    localparam logic [11:0] OFS_IDENT   = 12'h0FC;

    typedef enum logic [1:0] {
        SIG_OFF    = 2'd0,
        SIG_QUIET  = 2'd1,
        SIG_RAISED = 2'd2
    } sig_state_t;

endpackage

// File: rtl/cpuif_prio_pick.sv
module cpuif_prio_pick #(
    parameter int unsigned NUM_IRQ = 32,
    parameter int unsigned PRIO_W  = 8,
    localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]        pend,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic [PRIO_W-1:0]         best_prio,
    output logic [IDX_W-1:0]          best_idx,
    output logic                      found
);

    logic [PRIO_W-1:0] prio_arr [NUM_IRQ];

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
        assign prio_arr[g] = prio_flat[g*PRIO_W +: PRIO_W];
    end

    // Strict less-than while scanning upward keeps the lowest index on ties.
    always_comb begin
        found     = 1'b0;
        best_prio = '1;
        best_idx  = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend[i] && (!found || prio_arr[i] < best_prio)) begin
                found     = 1'b1;
                best_prio = prio_arr[i];
                best_idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cpuif_active_stack.sv
module cpuif_active_stack #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned IDX_W  = 5,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic              pop,
    output logic [PRIO_W-1:0] top_prio,
    output logic [IDX_W-1:0]  top_idx,
    output logic              empty,
    output logic              full
);

    logic [CNT_W-1:0]  level;
    logic [PRIO_W-1:0] prio_q [DEPTH];
    logic [IDX_W-1:0]  idx_q  [DEPTH];

    assign empty = (level == '0);
    assign full  = (level == CNT_W'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else if (push && !full) begin
            level <= level + 1'b1;
        end else if (pop && !empty) begin
            level <= level - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q[g] <= '1;
                idx_q[g]  <= '0;
            end else if (push && !full && level == CNT_W'(g)) begin
                prio_q[g] <= push_prio;
                idx_q[g]  <= push_idx;
            end
        end
    end

    always_comb begin
        top_prio = '1;
        top_idx  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level == CNT_W'(i + 1)) begin
                top_prio = prio_q[i];
                top_idx  = idx_q[i];
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9

endmodule

// File: rtl/cpuif_sig_fsm.sv
module cpuif_sig_fsm
    import cpuif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic qualify,
    output logic irq
);

    sig_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SIG_OFF: begin
                if (enable && qualify)      state_nx = SIG_RAISED; // T_ENABLE_RAISE
                else if (enable)            state_nx = SIG_QUIET;  // T_ENABLE
            end
            SIG_QUIET: begin
                if (!enable)                state_nx = SIG_OFF;    // T_DISABLE
                else if (qualify)           state_nx = SIG_RAISED; // T_RAISE
            end
            SIG_RAISED: begin
                if (!enable)                state_nx = SIG_OFF;    // T_DISABLE
                else if (!qualify)          state_nx = SIG_QUIET;  // T_DROP
            end
            default:                        state_nx = SIG_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SIG_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            SIG_RAISED: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq); // R5

endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
    import cpuif_pkg::*;
#(
    parameter int unsigned NUM_IRQ     = 32,
    parameter int unsigned PRIO_W      = 8,
    parameter int unsigned STACK_DEPTH = 4,
    parameter logic [31:0] IFACE_ID    = 32'h0002_0A5C,
    localparam int unsigned IDX_W      = $clog2(NUM_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        irq_pend,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [11:0]               bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      bus_rvalid,
    output logic                      irq_out,
    output logic                      claim_valid,
    output logic [ID_W-1:0]           claim_id,
    output logic                      done_valid,
    output logic [ID_W-1:0]           done_id
);

    logic              ctrl_en;
    logic [PRIO_W-1:0] pmask;
    logic [2:0]        split;
    logic [2:0]        split2;

    logic [PRIO_W-1:0] best_prio;
    logic [IDX_W-1:0]  best_idx;
    logic              best_found;

    logic [PRIO_W-1:0] top_prio;
    logic [IDX_W-1:0]  top_idx;
    logic              stk_empty, stk_full;

    logic [PRIO_W-1:0] running_prio;
    logic [PRIO_W-1:0] grp_mask;
    logic              qualify;
    logic              wr_fire, rd_fire;
    logic              claim_fire, retire_fire;
    logic [ID_W-1:0]   cand_id;
    logic [31:0]       rd_mux;

    cpuif_prio_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_pick (
        .pend      (irq_pend),
        .prio_flat (irq_prio),
        .best_prio (best_prio),
        .best_idx  (best_idx),
        .found     (best_found)
    );

    cpuif_active_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (claim_fire),
        .push_prio (best_prio),
        .push_idx  (best_idx),
        .pop       (retire_fire),
        .top_prio  (top_prio),
        .top_idx   (top_idx),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    cpuif_sig_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ctrl_en),
        .qualify (qualify),
        .irq     (irq_out)
    );

    // Group part keeps the bits above the split point (split+1 low bits dropped).
    assign grp_mask     = {PRIO_W{1'b1}} << ({1'b0, split} + 4'd1);
    assign running_prio = stk_empty ? {PRIO_W{1'b1}} : top_prio;
    assign qualify      = best_found && !stk_full && (best_prio < pmask) &&
                          (stk_empty || ((best_prio & grp_mask) < (running_prio & grp_mask)));
    assign cand_id      = qualify ? ID_W'(best_idx) : SPURIOUS_ID;

    assign wr_fire      = bus_wr;
    assign rd_fire      = bus_rd && !bus_wr;
    assign claim_fire   = rd_fire && (bus_addr == OFS_CLAIM) && qualify;
    assign retire_fire  = wr_fire && (bus_addr == OFS_DONE) && !stk_empty &&
                          (bus_wdata[ID_W-1:0] == ID_W'(top_idx));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            pmask   <= '0;
            split   <= '0;
            split2  <= '0;
        end else if (wr_fire) begin
            unique case (bus_addr)
                OFS_CTRL:   ctrl_en <= bus_wdata[0];
                OFS_PMASK:  pmask   <= bus_wdata[PRIO_W-1:0];
                OFS_SPLIT:  split   <= bus_wdata[2:0];
                OFS_SPLIT2: split2  <= bus_wdata[2:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL:   rd_mux = {31'd0, ctrl_en};
            OFS_PMASK:  rd_mux = 32'(pmask);
            OFS_SPLIT:  rd_mux = {29'd0, split};
            OFS_CLAIM:  rd_mux = 32'(cand_id);
            OFS_RUN:    rd_mux = 32'(running_prio);
            OFS_HIPEND: rd_mux = 32'(cand_id);
            OFS_SPLIT2: rd_mux = {29'd0, split2};
            OFS_IDENT:  rd_mux = IFACE_ID;
            default:    rd_mux = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rvalid  <= 1'b0;
            bus_rdata   <= '0;
            claim_valid <= 1'b0;
            claim_id    <= '0;
            done_valid  <= 1'b0;
            done_id     <= '0;
        end else begin
            bus_rvalid  <= rd_fire;
            if (rd_fire) bus_rdata <= rd_mux;
            claim_valid <= claim_fire;
            if (claim_fire) claim_id <= ID_W'(best_idx);
            done_valid  <= retire_fire;
            if (retire_fire) done_id <= ID_W'(top_idx);
        end
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(ctrl_en)); // R5
    AST_CLAIM_REAL: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |-> claim_id != SPURIOUS_ID); // R7
    AST_RUN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |-> running_prio < $past(running_prio)); // R6
    AST_UNDER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |-> running_prio < $past(pmask)); // R4
    AST_EOI_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> running_prio > $past(running_prio)); // R9

endmodule

// File: tb/test_cpu_irq_iface.sv
module test_cpu_irq_iface;
    import cpuif_pkg::*;

    localparam int unsigned NI  = 16;
    localparam int unsigned PW  = 8;
    localparam logic [31:0] IDV = 32'h0002_0A5C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NI-1:0]     pend = '0;
    logic [NI*PW-1:0]  prio = '0;
    logic [11:0]       addr = '0;
    logic              wr = 1'b0, rd = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              rvalid, irq, cv, dv;
    logic [ID_W-1:0]   cid, did;

    int total = 0;
    int bad = 0;
    int exp_q[$];
    string tag_q[$];
    logic last_cv, last_dv;
    logic [ID_W-1:0] last_cid, last_did;

    always #2 clk = ~clk;

    cpu_irq_iface #(.NUM_IRQ(NI), .PRIO_W(PW), .STACK_DEPTH(4), .IFACE_ID(IDV)) i_cpu_irq_iface (
        .clk(clk), .rst_n(rst_n), .irq_pend(pend), .irq_prio(prio),
        .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
        .bus_rdata(rdata), .bus_rvalid(rvalid), .irq_out(irq),
        .claim_valid(cv), .claim_id(cid), .done_valid(dv), .done_id(did)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops one expected read per returned read.
    always @(negedge clk) begin
        if (rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected read return", 1, 0);
            end else begin
                chk(tag_q.pop_front(), int'(rdata), exp_q.pop_front());
            end
        end
    end

    task automatic bus_read(input logic [11:0] a, input int exp, input string req);
        @(negedge clk);
        addr = a; rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(negedge clk);
        rd = 1'b0;
        last_cv = cv; last_cid = cid;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        last_dv = dv; last_did = did;
    endtask

    task automatic set_prio(input int id, input logic [7:0] p);
        @(negedge clk);
        prio[id*PW +: PW] = p;
    endtask

    task automatic claim(input int exp, input string req);
        bus_read(OFS_CLAIM, exp, req);
        chk({req, " claim pulse"}, int'(last_cv), (exp != 1023) ? 1 : 0);
        if (exp != 1023) begin
            chk({req, " claim id"}, int'(last_cid), exp);
            pend[exp] = 1'b0;
        end
    endtask

    task automatic retire(input int id, input int exp_done, input string req);
        bus_write(OFS_DONE, 32'(id));
        chk({req, " done pulse"}, int'(last_dv), exp_done);
        if (exp_done == 1) chk({req, " done id"}, int'(last_did), id);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < int'(NI); i++) prio[i*PW +: PW] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq after reset", int'(irq), 0);
        bus_read(OFS_CTRL, 0, "R1 ctrl");
        bus_read(OFS_PMASK, 0, "R1 threshold");
        bus_read(OFS_SPLIT, 0, "R1 split");
        bus_read(OFS_RUN, 255, "R1 running");
        bus_read(OFS_HIPEND, 1023, "R1 pending query");
        claim(1023, "R1 claim");

        // R2 register map
        bus_read(OFS_IDENT, int'(IDV), "R2 identity");
        bus_read(12'h020, 0, "R2 unmapped");
        bus_read(OFS_DONE, 0, "R2 completion reads 0");
        bus_write(OFS_SPLIT2, 32'd5);
        bus_read(OFS_SPLIT2, 5, "R2 spare split");
        bus_write(OFS_SPLIT, 32'hFF);
        bus_read(OFS_SPLIT, 7, "R2 split width");
        bus_write(OFS_PMASK, 32'h1234);
        bus_read(OFS_PMASK, 32'h34, "R2 threshold width");
        bus_write(OFS_CTRL, 32'hFFFF);
        bus_read(OFS_CTRL, 1, "R2 ctrl width");
        bus_write(OFS_CTRL, 32'h0);

        // R3 / R4 selection and threshold
        set_prio(3, 8'h40); set_prio(5, 8'h40); set_prio(9, 8'h60);
        pend[3] = 1'b1; pend[5] = 1'b1; pend[9] = 1'b1;
        bus_write(OFS_PMASK, 32'h40);
        bus_read(OFS_HIPEND, 1023, "R4 equal to threshold");
        bus_write(OFS_PMASK, 32'h41);
        bus_read(OFS_HIPEND, 3, "R3 tie lowest number");
        bus_write(OFS_PMASK, 32'hF0);
        set_prio(12, 8'h20); pend[12] = 1'b1;
        bus_read(OFS_HIPEND, 12, "R3 smallest value wins");
        pend[12] = 1'b0;
        bus_write(OFS_SPLIT, 32'd2);

        // R5 enable gating
        @(negedge clk);
        chk("R5 disabled line low", int'(irq), 0);
        bus_write(OFS_CTRL, 32'd1);
        @(negedge clk);
        chk("R5 line raised", int'(irq), 1);

        // R6 claim, R11 drop
        claim(3, "R6");
        bus_read(OFS_RUN, 32'h40, "R6 running after claim");
        chk("R11 line dropped", int'(irq), 0);

        // R8 / R7 no preemption at same group
        bus_read(OFS_HIPEND, 1023, "R8 same group held");
        claim(1023, "R7");
        bus_read(OFS_RUN, 32'h40, "R7 running unchanged");

        // R8 split point decides preemption
        set_prio(9, 8'h3E);
        bus_write(OFS_SPLIT, 32'd6);
        bus_read(OFS_HIPEND, 1023, "R8 coarse split blocks");
        chk("R8 line low coarse", int'(irq), 0);
        bus_write(OFS_SPLIT, 32'd0);
        bus_read(OFS_HIPEND, 9, "R8 fine split preempts");
        chk("R8 line high fine", int'(irq), 1);
        claim(9, "R8 nested");
        bus_read(OFS_RUN, 32'h3E, "R8 running nested");

        // R9 completion
        retire(3, 0, "R9 wrong number");
        bus_read(OFS_RUN, 32'h3E, "R9 wrong number ignored");
        retire(9, 1, "R9 pop");
        bus_read(OFS_RUN, 32'h40, "R9 restored");
        retire(3, 1, "R9 last");
        bus_read(OFS_RUN, 255, "R9 idle");
        retire(3, 0, "R9 empty");
        bus_read(OFS_RUN, 255, "R9 empty ignored");

        // R10 store depth
        pend = '0;
        bus_write(OFS_PMASK, 32'hFF);
        for (int k = 0; k < 4; k++) begin
            set_prio(k, 8'(8'h50 - 8'h10 * k));
            pend[k] = 1'b1;
            claim(k, "R10 fill");
            bus_read(OFS_RUN, 32'h50 - 32'h10 * k, "R10 running");
        end
        set_prio(4, 8'h10); pend[4] = 1'b1;
        bus_read(OFS_HIPEND, 1023, "R10 full blocks");
        claim(1023, "R10 full claim");
        retire(3, 1, "R10 free");
        bus_read(OFS_RUN, 32'h30, "R10 running after free");
        bus_read(OFS_HIPEND, 4, "R10 qualifies after free");

        repeat (2) @(negedge clk);
        chk("R2 all reads returned", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule